// File: doc/BRIEF.md
# UART Register Interface

This block is the processor-side register file of a single-channel asynchronous serial port. A one-cycle access strobe (`cs`) selects a register. The register-select line `rs` and the direction line `rw` pick one of four registers. With `rs` low, a write goes to the control register and a read returns the status register. With `rs` high, a write loads the transmit holding register and a read returns the last received character. Any side effect of an access happens on the clock edge that ends the access cycle. Read data is combinational for the cycle in which `cs` is high.

The control register sets up the rest of the port. It supplies the clock ratio and the character format to the serial engines. It drives the active-low request-to-send line and can hold the line in break. It enables the transmit and receive interrupts. The block keeps the status flags and raises an active-low interrupt. It also follows the active-low clear-to-send and carrier-detect inputs. The transmit and receive shift engines sit outside the block and connect through small handshake ports.

Top module: `uart_regif`

## Requirements
- R1: A read with `rs`=0 returns the status byte and a read with `rs`=1 returns the receive data, both while `cs` is high. A control write copies bits 1:0 to `clk_ratio` and bits 4:2 to `char_fmt` unchanged. For example, 0x19 gives ratio 01 and format 110, which the engines take as 8 data bits, even parity and 1 stop bit.
- R2: Control bits 1:0 = 11, or `rst_n` low, put the block in master reset. In that state `engine_hold`=1, `irq_n`=1, `send_req_n`=1 and `rx_done` is ignored. One clock after entry every status flag reads 0 except bit 1, which reads 1 while `modem_ready_n` is low (status 0x02). Only a control write with bits 1:0 other than 11 ends master reset.
- R3: Control bits 6:5 set the transmit side. 00 gives `send_req_n`=0 with the transmit interrupt off. 01 gives `send_req_n`=0 with the transmit interrupt on. 10 gives `send_req_n`=1 with the transmit interrupt off. 11 gives `send_req_n`=0 and `tx_break`=1 with the transmit interrupt off.
- R4: Status bit 0 (receive full) is set on the clock edge where `rx_done` is accepted. A receive data read clears it. `carrier_n` high clears it, and while `carrier_n` is high `rx_done` is ignored.
- R5: Status bit 1 (transmit empty) reads 0 from the edge of a transmit data write until the engine takes the byte. It also reads 0 whenever `modem_ready_n` is high.
- R6: Status bit 2 is set on the edge where `carrier_n` is first seen high. It stays set after `carrier_n` returns low. It clears only on a receive data read that comes after a status read made while the bit was set.
- R7: Status bit 3 equals `modem_ready_n`. While `modem_ready_n` is high, `tx_valid` is 0.
- R8: Status bit 5 (overrun) is set when a character is accepted while bit 0 is set and no receive data read occurs in the same cycle. The new character replaces the held one. A receive data read clears the bit.
- R9: Status bit 6 (parity error) and bit 4 (framing error) are loaded from `rx_perr` and `rx_ferr` with each accepted character. A receive data read clears bit 6. Bit 4 stays set until the next character is accepted.
- R10: Status bit 7 and `irq_n` (active low) are asserted when control bit 7 is set and any of status bits 0, 5 or 2 is set. They are also asserted when the transmit interrupt is on and status bit 1 is set.
- R11: A transmit data write places the byte on `tx_data`. `tx_valid` is 1 while the byte is pending and `modem_ready_n` is low. A `tx_take` pulse while `tx_valid` is 1 returns the register to empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; enters master reset |
| cs | input | 1 | Access strobe, one cycle per access |
| rs | input | 1 | Register select: 0 control/status, 1 data |
| rw | input | 1 | 1 read, 0 write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| irq_n | output | 1 | Interrupt request, active low |
| send_req_n | output | 1 | Request-to-send, active low |
| modem_ready_n | input | 1 | Clear-to-send, active low |
| carrier_n | input | 1 | Carrier detect, active low |
| clk_ratio | output | 2 | Clock ratio field to the engines |
| char_fmt | output | 3 | Character format field to the engines |
| tx_break | output | 1 | Transmit engine holds the line low |
| engine_hold | output | 1 | Master reset in force |
| tx_valid | output | 1 | Transmit byte pending and allowed |
| tx_data | output | 8 | Transmit byte |
| tx_take | input | 1 | Transmit engine consumed the byte |
| rx_done | input | 1 | Receive engine delivers a character |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error of the delivered character |
| rx_ferr | input | 1 | Framing error of the delivered character |

## Verification
The assertions check the following rules on every cycle. A receive data read clears the full flag. A second character on a full register sets overrun. A transmit write clears the empty flag. A rising carrier line sets the sticky flag. Clear-to-send high blocks the transmit handshake. A break code never releases request-to-send. A full register with the receive interrupt enabled pulls the interrupt line. Once master reset has been in force for a clock, all flags are clear. Only the bench scenarios can show the ordered clear of the carrier flag, where a data read alone leaves it set and a status read followed by a data read clears it. They also show that the framing flag survives a read while the parity flag does not, that characters are ignored during master reset, and how each transmit-control code appears on the pins.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int REG_W = 8;
  localparam int RATIO_W = 2;
  localparam int FMT_W = 3;
  localparam logic [RATIO_W-1:0] RATIO_RST = 2'b11;

  typedef struct packed {
    logic req_n;
    logic tx_ie;
    logic brk;
  } txctl_t;

  // transmit-control field decode
  function automatic txctl_t decode_txctl(input logic [1:0] code);
    txctl_t t;
    t.req_n = (code == 2'b10);
    t.tx_ie = (code == 2'b01);
    t.brk   = (code == 2'b11);
    return t;
  endfunction

  function automatic logic irq_cond(input logic rx_ie, input logic tx_ie,
                                    input logic rxf, input logic ovr,
                                    input logic cdl, input logic txe);
    return (rx_ie & (rxf | ovr | cdl)) | (tx_ie & txe);
  endfunction

  function automatic logic [REG_W-1:0] pack_status(input logic irq, input logic par,
      input logic ovr, input logic frm, input logic cts, input logic cdl,
      input logic txe, input logic rxf);
    return {irq, par, ovr, frm, cts, cdl, txe, rxf};
  endfunction
endpackage

// File: rtl/uart_regif_ctrl.sv
module uart_regif_ctrl
  import uart_regif_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_ctrl_ev,
  input  logic [REG_W-1:0]     wdata,
  output logic                 held,
  output logic [RATIO_W-1:0]   ratio,
  output logic [FMT_W-1:0]     fmt,
  output txctl_t               txc,
  output logic                 rx_ie
);
  localparam int FMT_LO = RATIO_W;
  localparam int TXC_LO = RATIO_W + FMT_W;

  logic [REG_W-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= {{(REG_W-RATIO_W){1'b0}}, RATIO_RST};
    else if (wr_ctrl_ev) ctrl_q <= wdata;
  end

  assign ratio = ctrl_q[RATIO_W-1:0];
  assign fmt   = ctrl_q[FMT_LO +: FMT_W];
  assign txc   = decode_txctl(ctrl_q[TXC_LO +: 2]);
  assign rx_ie = ctrl_q[REG_W-1];
  assign held  = (ratio == RATIO_RST);
endmodule

// File: rtl/uart_regif_rx.sv
module uart_regif_rx
  import uart_regif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             held,
  input  logic             rd_stat_ev,
  input  logic             rd_data_ev,
  input  logic             carrier_n,
  input  logic             rx_done,
  input  logic [REG_W-1:0] rx_data,
  input  logic             rx_perr,
  input  logic             rx_ferr,
  output logic [REG_W-1:0] rxd_q,
  output logic             rxf_q,
  output logic             ovr_q,
  output logic             cdl_q,
  output logic             frm_q,
  output logic             par_q,
  output logic             carrier_rise_ev,
  output logic             accept_ev
);
  logic carrier_q;
  logic cdl_arm_q;

  assign carrier_rise_ev = carrier_n & ~carrier_q;
  assign accept_ev       = rx_done & ~held & ~carrier_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carrier_q <= 1'b1;
    else        carrier_q <= carrier_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_q <= '0; rxf_q <= 1'b0; ovr_q <= 1'b0; cdl_q <= 1'b0;
      frm_q <= 1'b0; par_q <= 1'b0; cdl_arm_q <= 1'b0;
    end else if (held) begin
      rxd_q <= '0; rxf_q <= 1'b0; ovr_q <= 1'b0; cdl_q <= 1'b0;
      frm_q <= 1'b0; par_q <= 1'b0; cdl_arm_q <= 1'b0;
    end else begin
      rxf_q <= accept_ev | (rxf_q & ~rd_data_ev & ~carrier_n);
      ovr_q <= (ovr_q | (accept_ev & rxf_q)) & ~rd_data_ev;
      if (accept_ev) begin
        rxd_q <= rx_data;
        frm_q <= rx_ferr;
        par_q <= rx_perr;
      end else if (rd_data_ev) begin
        par_q <= 1'b0;
      end
      cdl_q     <= carrier_rise_ev | (cdl_q & ~(rd_data_ev & cdl_arm_q));
      cdl_arm_q <= rd_data_ev ? 1'b0 : (cdl_arm_q | (rd_stat_ev & cdl_q));
    end
  end
endmodule

// File: rtl/uart_regif_tx.sv
module uart_regif_tx
  import uart_regif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             held,
  input  logic             wr_data_ev,
  input  logic [REG_W-1:0] wdata,
  input  logic             tx_take,
  input  logic             modem_ready_n,
  output logic [REG_W-1:0] tdr_q,
  output logic             empty_q,
  output logic             tx_valid
);
  assign tx_valid = ~empty_q & ~modem_ready_n & ~held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdr_q   <= '0;
      empty_q <= 1'b1;
    end else if (held) begin
      empty_q <= 1'b1;
    end else if (wr_data_ev) begin
      tdr_q   <= wdata;
      empty_q <= 1'b0;
    end else if (tx_take & tx_valid) begin
      empty_q <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs,
  input  logic               rs,
  input  logic               rw,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   rdata,
  output logic               irq_n,
  output logic               send_req_n,
  input  logic               modem_ready_n,
  input  logic               carrier_n,
  output logic [RATIO_W-1:0] clk_ratio,
  output logic [FMT_W-1:0]   char_fmt,
  output logic               tx_break,
  output logic               engine_hold,
  output logic               tx_valid,
  output logic [REG_W-1:0]   tx_data,
  input  logic               tx_take,
  input  logic               rx_done,
  input  logic [REG_W-1:0]   rx_data,
  input  logic               rx_perr,
  input  logic               rx_ferr
);
  // named access events
  logic wr_ctrl_ev, rd_stat_ev, wr_data_ev, rd_data_ev;
  assign wr_ctrl_ev = cs & ~rw & ~rs;
  assign rd_stat_ev = cs &  rw & ~rs;
  assign wr_data_ev = cs & ~rw &  rs;
  assign rd_data_ev = cs &  rw &  rs;

  logic   held_w, rx_ie_w, tx_ie_w;
  txctl_t txc_w;

  uart_regif_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl_ev(wr_ctrl_ev), .wdata(wdata),
    .held(held_w), .ratio(clk_ratio), .fmt(char_fmt), .txc(txc_w), .rx_ie(rx_ie_w)
  );

  logic [REG_W-1:0] rxd_w;
  logic rxf_w, ovr_w, cdl_w, frm_w, par_w, carrier_rise_ev, accept_ev;

  uart_regif_rx u_rx (
    .clk(clk), .rst_n(rst_n), .held(held_w), .rd_stat_ev(rd_stat_ev),
    .rd_data_ev(rd_data_ev), .carrier_n(carrier_n), .rx_done(rx_done),
    .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
    .rxd_q(rxd_w), .rxf_q(rxf_w), .ovr_q(ovr_w), .cdl_q(cdl_w),
    .frm_q(frm_w), .par_q(par_w), .carrier_rise_ev(carrier_rise_ev),
    .accept_ev(accept_ev)
  );

  logic empty_w;

  uart_regif_tx u_tx (
    .clk(clk), .rst_n(rst_n), .held(held_w), .wr_data_ev(wr_data_ev),
    .wdata(wdata), .tx_take(tx_take), .modem_ready_n(modem_ready_n),
    .tdr_q(tx_data), .empty_q(empty_w), .tx_valid(tx_valid)
  );

  logic txe_w, irq_w;
  logic [REG_W-1:0] stat_w;

  assign tx_ie_w = txc_w.tx_ie;
  assign txe_w   = empty_w & ~modem_ready_n;
  assign irq_w   = ~held_w & irq_cond(rx_ie_w, tx_ie_w, rxf_w, ovr_w, cdl_w, txe_w);
  assign stat_w  = pack_status(irq_w, par_w, ovr_w, frm_w, modem_ready_n, cdl_w, txe_w, rxf_w);

  assign rdata       = rs ? rxd_w : stat_w;
  assign irq_n       = ~irq_w;
  assign send_req_n  = held_w | txc_w.req_n;
  assign tx_break    = ~held_w & txc_w.brk;
  assign engine_hold = held_w;
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] stat,
  input logic       held,
  input logic       rd_data_ev,
  input logic       wr_data_ev,
  input logic       rx_done,
  input logic       carrier_n,
  input logic       modem_ready_n,
  input logic       tx_valid,
  input logic       irq_n,
  input logic       rx_ie,
  input logic       tx_break,
  input logic       send_req_n
);
  AST_HELD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> (!held || (!stat[0] && !stat[2] && !stat[5] && !stat[6] && !stat[7]))); // R2
  AST_BREAK_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    tx_break |-> !send_req_n); // R3
  AST_RXF_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_ev && !rx_done) |=> !stat[0]); // R4
  AST_TXE_WRITE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_ev && !held) |=> !stat[1]); // R5
  AST_CDL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(carrier_n) && $past(rst_n) && !held) |=> (held || stat[2])); // R6
  AST_CTS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    modem_ready_n |-> !tx_valid); // R7
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && stat[0] && !rd_data_ev && !carrier_n && !held) |=> (held || stat[5])); // R8
  AST_RX_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[0] && rx_ie && !held) |-> !irq_n); // R10
endmodule

bind uart_regif uart_regif_chk chk_i (
  .clk(clk), .rst_n(rst_n), .stat(stat_w), .held(held_w),
  .rd_data_ev(rd_data_ev), .wr_data_ev(wr_data_ev), .rx_done(rx_done),
  .carrier_n(carrier_n), .modem_ready_n(modem_ready_n), .tx_valid(tx_valid),
  .irq_n(irq_n), .rx_ie(rx_ie_w), .tx_break(tx_break), .send_req_n(send_req_n)
);

// File: tb/uart_regif_tb_top.sv
module uart_regif_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 0, rs = 0, rw = 0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq_n, send_req_n, tx_break, engine_hold, tx_valid;
  logic modem_ready_n = 0, carrier_n = 0;
  logic [1:0] clk_ratio;
  logic [2:0] char_fmt;
  logic [7:0] tx_data;
  logic tx_take = 0, rx_done = 0, rx_perr = 0, rx_ferr = 0;
  logic [7:0] rx_data = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  uart_regif dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rs(rs), .rw(rw), .wdata(wdata),
    .rdata(rdata), .irq_n(irq_n), .send_req_n(send_req_n),
    .modem_ready_n(modem_ready_n), .carrier_n(carrier_n),
    .clk_ratio(clk_ratio), .char_fmt(char_fmt), .tx_break(tx_break),
    .engine_hold(engine_hold), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_take(tx_take), .rx_done(rx_done), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); cs = 1; rs = sel; rw = 0; wdata = d;
    @(negedge clk); cs = 0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    @(negedge clk); cs = 1; rs = sel; rw = 1;
    #1 d = rdata;
    @(negedge clk); cs = 0;
  endtask

  task automatic rx_char(input logic [7:0] d, input logic pe, input logic fe);
    @(negedge clk); rx_done = 1; rx_data = d; rx_perr = pe; rx_ferr = fe;
    @(negedge clk); rx_done = 0;
  endtask

  task automatic stat_is(input string tag, input logic [7:0] exp);
    logic [7:0] v;
    rd(0, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset();
    chk("R2 hold after reset", engine_hold, 1);
    chk("R2 irq_n in reset", irq_n, 1);
    chk("R2 send_req_n in reset", send_req_n, 1);
    stat_is("R2 status after reset", 8'h02);
    rx_char(8'h99, 1, 1);
    stat_is("R2 rx ignored while held", 8'h02);
  endtask

  task automatic t_config();
    wr(0, 8'h19);
    chk("R2 hold released", engine_hold, 0);
    chk("R1 clk_ratio", clk_ratio, 2'b01);
    chk("R1 char_fmt", char_fmt, 3'b110);
    chk("R3 code00 req", send_req_n, 0);
    chk("R3 code00 brk", tx_break, 0);
    chk("R3 code00 irq", irq_n, 1);
    wr(0, 8'h59);
    chk("R3 code10 req", send_req_n, 1);
    chk("R3 code10 irq", irq_n, 1);
    wr(0, 8'h79);
    chk("R3 code11 brk", tx_break, 1);
    chk("R3 code11 req", send_req_n, 0);
    chk("R3 code11 irq", irq_n, 1);
    wr(0, 8'h39);
    chk("R3 code01 req", send_req_n, 0);
    chk("R3 code01 irq", irq_n, 0);
    stat_is("R10 tx irq status", 8'h82);
    wr(0, 8'h19);
  endtask

  task automatic t_rx();
    logic [7:0] v;
    rx_char(8'hA5, 1, 0);
    stat_is("R9 parity latched", 8'h43);
    rd(1, v); chk("R1 rx data read", v, 8'hA5);
    stat_is("R4 R9 cleared by read", 8'h02);
    rx_char(8'h3C, 0, 1);
    stat_is("R9 framing latched", 8'h13);
    rd(1, v); chk("R1 rx data 2", v, 8'h3C);
    stat_is("R9 framing survives read", 8'h12);
    rx_char(8'h11, 0, 0);
    rx_char(8'h22, 0, 0);
    stat_is("R8 overrun set", 8'h23);
    rd(1, v); chk("R8 newest data kept", v, 8'h22);
    stat_is("R8 overrun cleared", 8'h02);
  endtask

  task automatic t_tx();
    wr(1, 8'h5A);
    chk("R11 tx_valid", tx_valid, 1);
    chk("R11 tx_data", tx_data, 8'h5A);
    stat_is("R5 empty cleared", 8'h00);
    @(negedge clk); modem_ready_n = 1;
    #1 chk("R7 tx inhibited", tx_valid, 0);
    stat_is("R7 cts bit", 8'h08);
    @(negedge clk); modem_ready_n = 0; tx_take = 1;
    @(negedge clk); tx_take = 0;
    chk("R11 taken", tx_valid, 0);
    stat_is("R11 empty again", 8'h02);
    @(negedge clk); modem_ready_n = 1;
    stat_is("R5 empty masked", 8'h08);
    @(negedge clk); modem_ready_n = 0;
  endtask

  task automatic t_carrier();
    logic [7:0] v;
    rx_char(8'h77, 0, 0);
    stat_is("R4 full before carrier", 8'h03);
    @(negedge clk); carrier_n = 1;
    @(negedge clk);
    rx_char(8'h44, 0, 0);
    stat_is("R4 R6 carrier high", 8'h0E - 8'h08);
    @(negedge clk); carrier_n = 0;
    rd(1, v);
    stat_is("R6 cleared after status+data", 8'h02);
    wr(0, 8'h99);
    chk("R10 no irq idle", irq_n, 1);
    @(negedge clk); carrier_n = 1;
    @(negedge clk); carrier_n = 0;
    @(negedge clk);
    chk("R6 R10 irq on carrier", irq_n, 0);
    rd(1, v);
    chk("R6 data read alone keeps", irq_n, 0);
    stat_is("R6 sticky status", 8'h86);
    rd(1, v);
    chk("R6 irq released", irq_n, 1);
    stat_is("R6 flag gone", 8'h02);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    rx_char(8'h5C, 0, 0);
    chk("R10 rx irq", irq_n, 0);
    stat_is("R10 rx irq status", 8'h83);
    rd(1, v);
    chk("R10 cleared by read", irq_n, 1);
    wr(0, 8'h39);
    chk("R10 tx irq on", irq_n, 0);
    wr(1, 8'hC3);
    chk("R10 cleared by write", irq_n, 1);
    @(negedge clk); tx_take = 1;
    @(negedge clk); tx_take = 0;
    chk("R10 tx irq after take", irq_n, 0);
    @(negedge clk); modem_ready_n = 1;
    #1 chk("R7 tx irq inhibited", irq_n, 1);
    @(negedge clk); modem_ready_n = 0;
    wr(0, 8'h19);
  endtask

  task automatic t_mreset();
    logic [7:0] v;
    wr(1, 8'hEE);
    rx_char(8'h12, 1, 1);
    rx_char(8'h13, 1, 1);
    stat_is("R8 prep", 8'h71);
    wr(0, 8'h03);
    chk("R2 hold by code", engine_hold, 1);
    stat_is("R2 flags cleared", 8'h02);
    rx_char(8'h55, 0, 0);
    stat_is("R2 still ignored", 8'h02);
    rd(1, v); chk("R2 data cleared", v, 8'h00);
    wr(0, 8'h19);
    chk("R2 released", engine_hold, 0);
    stat_is("R2 status after release", 8'h02);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=0x00 expected=0x01");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_config();
    t_rx();
    t_tx();
    t_carrier();
    t_irq();
    t_mreset();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule